// File: doc/BRIEF.md
# Bit Position Search Unit

This block takes one 32-bit operand and returns the position of the first qualifying bit met while scanning downward from the most significant bit. The position is counted as a distance from the MSB: the MSB is position 0 and the LSB is position 31. The value 32 means that no bit qualifies. Operating systems and schedulers use this kind of unit to find the highest-priority ready entry in a bitmap, or to count leading sign bits before normalising a value.

The caller writes the operand with a one-cycle strobe and a 2-bit selector that picks what counts as a qualifying bit:
- a set bit;
- a clear bit;
- a bit that differs from the operand's MSB.

The result register loads on that clock edge. It then holds its value until the next accepted write.

Top module: `bit_seek_unit`

## Requirements
- R1: With wr_sel = 2'b00 (find-one mode), a write loads pos_q with the distance from the MSB of the highest set bit of wr_data (MSB = 0, LSB = 31).
- R2: With wr_sel = 2'b01 (find-zero mode), a write loads pos_q with the distance from the MSB of the highest clear bit of wr_data.
- R3: With wr_sel = 2'b10 (find-change mode), bit 31 is the reference and the scan starts at bit 30. pos_q receives the distance from the MSB of the first bit not equal to bit 31, so a found result is always between 1 and 31.
- R4: When no bit qualifies in the selected mode, pos_q is loaded with 32. This covers an all-zero word in find-one mode, an all-ones word in find-zero mode, and a uniform word in find-change mode.
- R5: The result of a write is visible on pos_q after the rising clock edge at which wr_en is sampled high, and not before.
- R6: While wr_en is low, pos_q holds its value.
- R7: A write with wr_sel = 2'b11 is ignored and pos_q keeps its previous value.
- R8: While rst is high, and after it is released, pos_q reads 32 until the first accepted write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Operand write strobe |
| wr_sel | input | 2 | Search mode: 00 find one, 01 find zero, 10 find change, 11 reserved |
| wr_data | input | 32 | Operand word |
| pos_q | output | 6 | Result position from the MSB, 32 when nothing qualifies |

## Verification
Every search result is due one clock after the write. The bench sets the strobe at a falling edge and pushes the expected position once the next rising edge has passed. The monitor pops that entry at the following falling edge and compares it with pos_q, so each comparison falls exactly one edge after its write. Idle cycles and reserved-mode writes push the position expected from before, which checks that the result holds over each cycle without an accepted write.

// File: rtl/bsu_pkg.sv
package bsu_pkg;

    localparam int WORD_W  = 32;
    localparam int GROUP_W = 8;
    localparam int POS_W   = $clog2(WORD_W + 1);

    typedef enum logic [1:0] {
        SEEK_ONE  = 2'b00,
        SEEK_ZERO = 2'b01,
        SEEK_EDGE = 2'b10,
        SEEK_NONE = 2'b11
    } seek_mode_e;

    typedef struct packed {
        logic             hit;
        logic [POS_W-1:0] pos;
    } scan_res_t;

    function automatic logic mode_accepts(input seek_mode_e m);
        return m != SEEK_NONE;
    endfunction

endpackage

// File: rtl/bsu_qualify.sv
module bsu_qualify
    import bsu_pkg::*;
#(
    parameter int W = WORD_W
) (
    input  logic [W-1:0] word,
    input  seek_mode_e   mode,
    output logic [W-1:0] mask
);
    logic [W-1:0] diff;

    always_comb begin
        diff        = word ^ {W{word[W-1]}};
        diff[W-1]   = 1'b0;
        unique case (mode)
            SEEK_ONE:  mask = word;
            SEEK_ZERO: mask = ~word;
            SEEK_EDGE: mask = diff;
            default:   mask = '0;
        endcase
    end
endmodule

// File: rtl/bsu_group_scan.sv
module bsu_group_scan #(
    parameter int GW    = 8,
    localparam int OFF_W = (GW > 1) ? $clog2(GW) : 1
) (
    input  logic [GW-1:0]    bits,
    output logic             hit,
    output logic [OFF_W-1:0] off
);
    always_comb begin
        hit = 1'b0;
        off = '0;
        for (int i = 0; i < GW; i++) begin
            if (!hit && bits[GW-1-i]) begin
                hit = 1'b1;
                off = OFF_W'(i);
            end
        end
    end
endmodule

// File: rtl/bsu_lead_scan.sv
module bsu_lead_scan
    import bsu_pkg::*;
#(
    parameter int W  = WORD_W,
    parameter int GW = GROUP_W,
    localparam int NG    = W / GW,
    localparam int OFF_W = (GW > 1) ? $clog2(GW) : 1
) (
    input  logic [W-1:0] mask,
    output scan_res_t    res
);
    logic             g_hit [NG];
    logic [OFF_W-1:0] g_off [NG];

    for (genvar g = 0; g < NG; g++) begin : g_grp
        bsu_group_scan #(.GW(GW)) u_grp (
            .bits (mask[W-1-g*GW -: GW]),
            .hit  (g_hit[g]),
            .off  (g_off[g])
        );
    end

    always_comb begin
        res.hit = 1'b0;
        res.pos = POS_W'(W);
        for (int g = 0; g < NG; g++) begin
            if (!res.hit && g_hit[g]) begin
                res.hit = 1'b1;
                res.pos = POS_W'(g * GW) + POS_W'(g_off[g]);
            end
        end
    end
endmodule

// File: rtl/bit_seek_unit.sv
module bit_seek_unit
    import bsu_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [1:0]        wr_sel,
    input  logic [WORD_W-1:0] wr_data,
    output logic [POS_W-1:0]  pos_q
);
    seek_mode_e        mode;
    logic [WORD_W-1:0] mask;
    scan_res_t         scan;

    assign mode = seek_mode_e'(wr_sel);

    bsu_qualify #(.W(WORD_W)) u_qual (
        .word (wr_data),
        .mode (mode),
        .mask (mask)
    );

    bsu_lead_scan #(.W(WORD_W), .GW(GROUP_W)) u_scan (
        .mask (mask),
        .res  (scan)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            pos_q <= POS_W'(WORD_W);
        end else if (wr_en && mode_accepts(mode)) begin
            pos_q <= scan.pos;
        end
    end
endmodule

// File: rtl/bsu_checker.sv
module bsu_checker
    import bsu_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              wr_en,
    input logic [1:0]        wr_sel,
    input logic [WORD_W-1:0] wr_data,
    input logic [POS_W-1:0]  pos_q
);
    a_r1_msb_set: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_sel == 2'b00 && wr_data[WORD_W-1]) |=> pos_q == 0);

    a_r2_msb_clear: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_sel == 2'b01 && !wr_data[WORD_W-1]) |=> pos_q == 0);

    a_r3_change_nonzero: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_sel == 2'b10) |=> pos_q != 0);

    a_r4_empty_word: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_sel == 2'b00 && wr_data == '0) |=> pos_q == POS_W'(WORD_W));

    a_r4_in_range: assert property (@(posedge clk) disable iff (rst)
        pos_q <= POS_W'(WORD_W));

    a_r6_hold_idle: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(pos_q));

    a_r7_reserved: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_sel == 2'b11) |=> $stable(pos_q));
endmodule

bind bit_seek_unit bsu_checker u_chk (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_sel  (wr_sel),
    .wr_data (wr_data),
    .pos_q   (pos_q)
);

// File: tb/bit_seek_unit_tb.sv
module bit_seek_unit_tb;
    logic        clk = 1'b0;
    logic        rst;
    logic        wr_en;
    logic [1:0]  wr_sel;
    logic [31:0] wr_data;
    logic [5:0]  pos_q;

    int n_chk  = 0;
    int n_fail = 0;
    int cycles = 0;
    bit done   = 0;
    int last_exp = 32;

    typedef struct {
        int    exp;
        string tag;
    } item_t;
    item_t sb[$];

    always #5 clk = ~clk;

    bit_seek_unit u_dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .pos_q(pos_q)
    );

    function automatic int model(input logic [31:0] d, input logic [1:0] m);
        for (int p = 0; p < 32; p++) begin
            logic b;
            b = d[31-p];
            if (m == 2'b00 && b) return p;
            if (m == 2'b01 && !b) return p;
            if (m == 2'b10 && p >= 1 && b != d[31]) return p;
        end
        return 32;
    endfunction

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    endtask

    task automatic check(input int act, input int exp, input string tag);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: pos_q=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic apply(input logic en, input logic [1:0] sel,
                         input logic [31:0] d, input string tag);
        item_t it;
        @(negedge clk);
        wr_en = en; wr_sel = sel; wr_data = d;
        @(posedge clk);
        if (en && sel != 2'b11) last_exp = model(d, sel);
        it.exp = last_exp;
        it.tag = tag;
        sb.push_back(it);
        #1 wr_en = 1'b0;
    endtask

    always @(negedge clk) begin
        if (sb.size() > 0) begin
            item_t it;
            it = sb.pop_front();
            check(int'(pos_q), it.exp, it.tag);
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: cycles=%0d expected=done", cycles);
            finish_run();
        end
    end

    initial begin
        logic [31:0] lf;
        rst = 1'b1; wr_en = 1'b0; wr_sel = 2'b00; wr_data = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(int'(pos_q), 32, "R8 during reset");
        rst = 1'b0;
        @(negedge clk);
        check(int'(pos_q), 32, "R8 after reset");

        // R5: not visible before the edge
        @(negedge clk);
        wr_en = 1'b1; wr_sel = 2'b00; wr_data = 32'h0000_0001;
        #2 check(int'(pos_q), 32, "R5 before edge");
        @(posedge clk); #1 wr_en = 1'b0;
        @(negedge clk);
        check(int'(pos_q), 31, "R5 after edge");
        last_exp = 31;

        apply(1, 2'b00, 32'h8000_0000, "R1 msb set");
        apply(1, 2'b00, 32'h0001_0000, "R1 mid bit");
        apply(1, 2'b00, 32'h0000_0000, "R4 find-one empty");
        apply(1, 2'b01, 32'h0000_0000, "R2 msb clear");
        apply(1, 2'b01, 32'hFFFF_FFFE, "R2 lsb clear");
        apply(1, 2'b01, 32'hFFFF_FFFF, "R4 find-zero full");
        apply(1, 2'b10, 32'hC000_0000, "R3 change at bit 29");
        apply(1, 2'b10, 32'h7FFF_FFFF, "R3 change at bit 30");
        apply(1, 2'b10, 32'hFFFF_FFFE, "R3 change at lsb");
        apply(1, 2'b10, 32'hFFFF_FFFF, "R4 change uniform ones");
        apply(1, 2'b10, 32'h0000_0000, "R4 change uniform zeros");
        apply(1, 2'b00, 32'h0000_0400, "R1 bit 10");
        apply(0, 2'b00, 32'h8000_0000, "R6 idle hold");
        apply(0, 2'b01, 32'h0000_0000, "R6 idle hold 2");
        apply(1, 2'b11, 32'h8000_0000, "R7 reserved ignored");
        apply(1, 2'b11, 32'h0000_0000, "R7 reserved ignored 2");

        lf = 32'hACE1_1234;
        for (int k = 0; k < 90; k++) begin
            lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
            case (k % 3)
                0: apply(1, 2'b00, lf >> (k % 29), "R1 sweep");
                1: apply(1, 2'b01, ~(lf >> (k % 29)), "R2 sweep");
                default: apply(1, 2'b10, (k[0] ? ~lf : lf) >> (k % 7) | (k[1] ? 32'h8000_0000 : 32'h0), "R3 sweep");
            endcase
        end
        apply(0, 2'b00, 32'h0, "R6 final hold");
        @(negedge clk);
        @(negedge clk);
        finish_run();
    end
endmodule